// File: doc/BRIEF.md
# Three-Operand Opcode ALU

A purely combinational arithmetic and logic unit with three data operands, A, B and M, all WIDTH bits wide. A 4-bit opcode selects one of thirteen operations: add, subtract, bitwise AND, OR, XOR and bitwise inversion. Each two-operand opcode names its second operand. That operand is either B or M, so one opcode value fixes both the operation and the source. The inversion opcodes act on one operand alone.

Sums and differences wrap modulo 2^WIDTH. No carry, borrow or flag is produced. The three opcode values left unassigned force the result to zero. The block holds no state, and a user who needs a registered result places a register after it.

Top module: `alu3_top`

## Requirements
- R1: Opcode 4'b0000 gives R = A + B and opcode 4'b0001 gives R = A + M. The sum is taken modulo 2^WIDTH and the carry is dropped.
- R2: Opcode 4'b0010 gives R = A - B and opcode 4'b0011 gives R = A - M. The difference is taken modulo 2^WIDTH and the borrow is dropped.
- R3: Opcodes 4'b0100, 4'b0101 and 4'b0110 give the bitwise inverse of A, of B and of M respectively.
- R4: Opcode 4'b0111 gives A AND B and opcode 4'b1000 gives A AND M.
- R5: Opcode 4'b1001 gives A OR B and opcode 4'b1010 gives A OR M.
- R6: Opcode 4'b1011 gives A XOR B and opcode 4'b1100 gives A XOR M.
- R7: Opcodes 4'b1101, 4'b1110 and 4'b1111 drive R to all zeros, whatever the operands are.
- R8: The operand an opcode does not name has no effect on R. M does not affect the B-form opcodes, and B does not affect the M-form opcodes.
- R9: The data width is the parameter WIDTH with default 8. Zero and all-ones operands give the wrapped results, for example all-ones + 1 = 0 and 0 - 1 = all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand A, used by every opcode except the B and M inversions |
| opb_i | input | WIDTH | Operand B |
| opm_i | input | WIDTH | Operand M |
| op_i | input | 4 | Operation select |
| res_o | output | WIDTH | Result R |

## Verification
The embedded checks run only while all operands and the opcode are free of X and Z. Each check relates the result back to its inputs: a sum minus the named operand gives A back, and a difference plus the named operand gives A back. The bench drives only fully known values and changes inputs half a cycle before it samples, so every check sees settled data. To exercise R8, the bench holds A, the named operand and the opcode fixed while it changes the unnamed operand.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

  typedef enum logic [3:0] {
    OP_ADD_AB = 4'b0000,
    OP_ADD_AM = 4'b0001,
    OP_SUB_AB = 4'b0010,
    OP_SUB_AM = 4'b0011,
    OP_NOT_A  = 4'b0100,
    OP_NOT_B  = 4'b0101,
    OP_NOT_M  = 4'b0110,
    OP_AND_AB = 4'b0111,
    OP_AND_AM = 4'b1000,
    OP_OR_AB  = 4'b1001,
    OP_OR_AM  = 4'b1010,
    OP_XOR_AB = 4'b1011,
    OP_XOR_AM = 4'b1100
  } opcode_e;

  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_ZERO} cls_e;
  typedef enum logic [1:0] {SRC_A, SRC_B, SRC_M} src_e;
  typedef enum logic [1:0] {LOP_NOT, LOP_AND, LOP_OR, LOP_XOR} lop_e;

  typedef struct packed {
    cls_e cls;
    logic sub;
    lop_e lop;
    src_e src;
  } dec_t;

endpackage

// File: rtl/alu3_decode.sv
module alu3_decode
  import alu3_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o.cls = CLS_ZERO;
    dec_o.sub = 1'b0;
    dec_o.lop = LOP_AND;
    dec_o.src = SRC_B;
    case (op_i)
      OP_ADD_AB: begin dec_o.cls = CLS_ARITH; end
      OP_ADD_AM: begin dec_o.cls = CLS_ARITH; dec_o.src = SRC_M; end
      OP_SUB_AB: begin dec_o.cls = CLS_ARITH; dec_o.sub = 1'b1; end
      OP_SUB_AM: begin dec_o.cls = CLS_ARITH; dec_o.sub = 1'b1; dec_o.src = SRC_M; end
      OP_NOT_A:  begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_NOT; dec_o.src = SRC_A; end
      OP_NOT_B:  begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_NOT; end
      OP_NOT_M:  begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_NOT; dec_o.src = SRC_M; end
      OP_AND_AB: begin dec_o.cls = CLS_LOGIC; end
      OP_AND_AM: begin dec_o.cls = CLS_LOGIC; dec_o.src = SRC_M; end
      OP_OR_AB:  begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_OR; end
      OP_OR_AM:  begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_OR; dec_o.src = SRC_M; end
      OP_XOR_AB: begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_XOR; end
      OP_XOR_AM: begin dec_o.cls = CLS_LOGIC; dec_o.lop = LOP_XOR; dec_o.src = SRC_M; end
      default:   ;
    endcase
  end

  // unassigned codes must never reach a datapath class
  always_comb begin
    if (!$isunknown(op_i) && op_i > 4'b1100)
      p_unused_class_r7: assert (dec_o.cls == CLS_ZERO)
        else $error("unused opcode decoded to live class");
  end

endmodule

// File: rtl/alu3_arith.sv
module alu3_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] b_eff;

  // one adder: subtract as a + ~b + 1, carry out discarded
  assign b_eff = b_i ^ {WIDTH{sub_i}};
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (sub_i) p_sub_inverse_r2: assert (sum_o + b_i == a_i)
        else $error("difference does not invert");
      else       p_add_inverse_r1: assert (sum_o - b_i == a_i)
        else $error("sum does not invert");
    end
  end

endmodule

// File: rtl/alu3_logic.sv
module alu3_logic
  import alu3_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] n_i,
  input  lop_e             lop_i,
  output logic [WIDTH-1:0] res_o
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    always_comb begin
      case (lop_i)
        LOP_NOT: res_o[gi] = ~n_i[gi];
        LOP_AND: res_o[gi] = a_i[gi] & y_i[gi];
        LOP_OR:  res_o[gi] = a_i[gi] | y_i[gi];
        default: res_o[gi] = a_i[gi] ^ y_i[gi];
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({a_i, y_i, n_i, lop_i})) begin
      if (lop_i == LOP_AND) p_and_subset_r4: assert ((res_o & ~a_i) == '0 && (res_o & ~y_i) == '0)
        else $error("and result has stray bits");
      if (lop_i == LOP_OR) p_or_superset_r5: assert ((res_o & a_i) == a_i && (res_o & y_i) == y_i)
        else $error("or result drops bits");
      if (lop_i == LOP_XOR) p_xor_recover_r6: assert ((res_o ^ a_i) == y_i)
        else $error("xor does not recover operand");
      if (lop_i == LOP_NOT) p_not_complement_r3: assert ((res_o ^ n_i) == {WIDTH{1'b1}})
        else $error("not is not a complement");
    end
  end

endmodule

// File: rtl/alu3_top.sv
module alu3_top
  import alu3_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [WIDTH-1:0] opm_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  dec_t             dec;
  logic [WIDTH-1:0] sec_op;
  logic [WIDTH-1:0] not_op;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;

  alu3_decode u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  // second operand picked once, shared by both units
  assign sec_op = (dec.src == SRC_M) ? opm_i : opb_i;
  assign not_op = (dec.src == SRC_A) ? opa_i : sec_op;

  alu3_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i   (opa_i),
    .b_i   (sec_op),
    .sub_i (dec.sub),
    .sum_o (arith_res)
  );

  alu3_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (opa_i),
    .y_i   (sec_op),
    .n_i   (not_op),
    .lop_i (dec.lop),
    .res_o (logic_res)
  );

  always_comb begin
    case (dec.cls)
      CLS_ARITH: res_o = arith_res;
      CLS_LOGIC: res_o = logic_res;
      default:   res_o = '0;
    endcase
  end

  // end-to-end checks keyed on raw opcode
  always_comb begin
    if (!$isunknown({opa_i, opb_i, opm_i, op_i})) begin
      case (op_i)
        4'b0000: p_top_add_b_r1: assert (res_o - opb_i == opa_i) else $error("add A+B");
        4'b0001: p_top_add_m_r8: assert (res_o - opm_i == opa_i) else $error("add A+M");
        4'b0010: p_top_sub_b_r2: assert (res_o + opb_i == opa_i) else $error("sub A-B");
        4'b0011: p_top_sub_m_r8: assert (res_o + opm_i == opa_i) else $error("sub A-M");
        4'b1101, 4'b1110, 4'b1111:
          p_top_unused_zero_r7: assert (res_o == '0) else $error("unused opcode nonzero");
        default: ;
      endcase
    end
  end

endmodule

// File: tb/tb_alu3_top.sv
module tb_alu3_top;

  localparam int WIDTH      = 8;
  localparam int CLK_PERIOD = 10;
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic             clk = 1'b0;
  logic [WIDTH-1:0] opa, opb, opm;
  logic [3:0]       op;
  logic [WIDTH-1:0] res;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu3_top #(.WIDTH(WIDTH)) dut (
    .opa_i (opa),
    .opb_i (opb),
    .opm_i (opm),
    .op_i  (op),
    .res_o (res)
  );

  function automatic logic [WIDTH-1:0] model(input logic [3:0] o,
      input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic [WIDTH-1:0] m);
    case (o)
      4'd0:  return a + b;
      4'd1:  return a + m;
      4'd2:  return a - b;
      4'd3:  return a - m;
      4'd4:  return ~a;
      4'd5:  return ~b;
      4'd6:  return ~m;
      4'd7:  return a & b;
      4'd8:  return a & m;
      4'd9:  return a | b;
      4'd10: return a | m;
      4'd11: return a ^ b;
      4'd12: return a ^ m;
      default: return '0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic [WIDTH-1:0] m);
    @(negedge clk);
    op = o; opa = a; opb = b; opm = m;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h m=%h actual=%h expected=%h",
               req, op, opa, opb, opm, res, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] o, input logic [WIDTH-1:0] a,
                     input logic [WIDTH-1:0] b, input logic [WIDTH-1:0] m);
    apply(o, a, b, m);
    check(req, model(o, a, b, m));
  endtask

  task automatic t_idle_state();
    run("R1", 4'd0, '0, '0, '0);
    run("R7", 4'd15, '0, '0, '0);
  endtask

  task automatic t_add();
    run("R1", 4'd0, 8'h12, 8'h34, 8'hAA);
    run("R1", 4'd1, 8'h12, 8'h55, 8'h21);
    for (int i = 0; i < 20; i++)
      run("R1", 4'(i % 2), WIDTH'($urandom), WIDTH'($urandom), WIDTH'($urandom));
  endtask

  task automatic t_sub();
    run("R2", 4'd2, 8'h50, 8'h10, 8'h01);
    run("R2", 4'd3, 8'h50, 8'h01, 8'h20);
    for (int i = 0; i < 20; i++)
      run("R2", 4'(2 + i % 2), WIDTH'($urandom), WIDTH'($urandom), WIDTH'($urandom));
  endtask

  task automatic t_not();
    run("R3", 4'd4, 8'h0F, 8'h33, 8'hC3);
    run("R3", 4'd5, 8'h0F, 8'h33, 8'hC3);
    run("R3", 4'd6, 8'h0F, 8'h33, 8'hC3);
  endtask

  task automatic t_bitwise();
    for (int i = 0; i < 10; i++) begin
      logic [WIDTH-1:0] a = WIDTH'($urandom);
      logic [WIDTH-1:0] b = WIDTH'($urandom);
      logic [WIDTH-1:0] m = WIDTH'($urandom);
      run("R4", 4'd7, a, b, m);
      run("R4", 4'd8, a, b, m);
      run("R5", 4'd9, a, b, m);
      run("R5", 4'd10, a, b, m);
      run("R6", 4'd11, a, b, m);
      run("R6", 4'd12, a, b, m);
    end
  endtask

  task automatic t_unused();
    for (int o = 13; o < 16; o++) begin
      run("R7", 4'(o), ONES, ONES, ONES);
      run("R7", 4'(o), 8'h5A, 8'hA5, 8'h3C);
    end
  endtask

  // R8: unnamed operand changes, result must not move
  task automatic t_unnamed_operand();
    for (int o = 0; o < 13; o++) begin
      logic [WIDTH-1:0] keep;
      if (o == 4) continue;
      apply(4'(o), 8'h6C, 8'h39, 8'hC5);
      keep = res;
      check("R8", model(4'(o), 8'h6C, 8'h39, 8'hC5));
      if (o inside {0, 2, 5, 7, 9, 11}) apply(4'(o), 8'h6C, 8'h39, 8'h1E);
      else                              apply(4'(o), 8'h6C, 8'hE1, 8'hC5);
      check("R8", keep);
    end
  endtask

  task automatic t_corners();
    run("R9", 4'd0, ONES, 8'h01, '0);
    check("R9", '0);
    run("R9", 4'd3, '0, '0, 8'h01);
    check("R9", ONES);
    run("R9", 4'd1, ONES, '0, ONES);
    run("R9", 4'd2, '0, ONES, '0);
    run("R9", 4'd4, '0, '0, '0);
    run("R9", 4'd6, '0, '0, ONES);
    run("R9", 4'd12, ONES, '0, ONES);
    run("R9", 4'd9, '0, ONES, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    op = '0; opa = '0; opb = '0; opm = '0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_add();
    t_sub();
    t_not();
    t_bitwise();
    t_unused();
    t_unnamed_operand();
    t_corners();
    finish_run();
  end

endmodule